// File: doc/BRIEF.md
# MAC address table command engine

This block holds a small table of learned Ethernet addresses for a switch and runs table maintenance commands that a host issues through six 16-bit registers. The host places a 48-bit MAC address, a data word (entry state, trunk flag, port vector) and a database number in the registers. It then writes the command register with its busy bit set. The engine walks the whole table one slot per clock, applies the command and drops busy. For a get-next command it leaves the found entry in the MAC and data registers.

Four command families exist. Load/purge writes, overwrites or removes the entry keyed by MAC and database. Get-next iterates the valid entries of one database in ascending MAC order. Flush removes entries. Move reassigns entries from one port to another, or drops a port from them. Flush and move can cover every database or only one, and can touch every entry or spare the static ones. The same data-register state value selects between flush and move. The control register also carries an age-time setting and a learn-to-all enable, which the block only stores and exports.

Top module: `mac_tbl_engine`

## Requirements
- R1: After reset, busy is 0 and the table is empty. The control register reads 0x0140 (age-time 20, learn-to-all off), and the command and data registers read 0.
- R2: Register map (reg_addr):
  - 0 is control.
  - 1 is command: bit 15 busy, bits 14:12 opcode, bits 3:0 database low nibble.
  - 2 is data.
  - 3..5 are MAC words.

  A host write to address 1 with bit 15 set starts a command, and busy reads 1 from the next cycle. Busy stays 1 for exactly DEPTH+1 cycles. Host writes made while busy are ignored.

  Opcodes:
  - 1: flush/move all entries in all databases.
  - 2: flush/move non-static entries in all databases.
  - 3: load/purge.
  - 4: get-next.
  - 5: flush/move all entries in one database.
  - 6: flush/move non-static entries in one database.
  - Any other value: no effect.
- R3: The 8-bit database number is control bits 15:12 (upper nibble) concatenated with command bits 3:0 (lower nibble). Commands restricted to one database neither see nor change entries of another.
- R4: The data register holds the state in bits 3:0, the port vector in bits 11:4 and the trunk flag in bit 15. The MAC words at addresses 3, 4 and 5 hold bytes 0-1, 2-3 and 4-5, with the lower-numbered byte in bits 15:8; byte 0 is the most significant.
- R5: Load with a nonzero state writes a new entry into a free slot, or overwrites the entry with the same MAC and database.
- R6: Load with state 0 removes the entry with the same MAC and database.
- R7: Get-next returns, in the MAC and data registers, the valid entry of the selected database with the smallest MAC above the MAC registers. When none is left, it returns state 0, a zero data word and an all-ones MAC.
- R8: An all-ones MAC as the start key makes get-next return the lowest MAC in the database.
- R9: Flush (data state 0) clears every selected entry. The non-static variants spare entries with state 0xE.
- R10: Move (data state 0xF) uses data bits 7:4 as the source port number and bits 11:8 as the destination port number. In each selected entry whose vector has the source bit set, that bit is cleared and the destination bit is set.
- R11: A move to destination 0xF only clears the source bit. An entry whose vector becomes empty is removed.
- R12: The control register holds age-time in bits 11:4 and learn-to-all in bit 3, both exported as ports. A write whose age-time field is 0 keeps the previous age-time.
- R13: A load of a new key into a full table is dropped. Overwrites of existing keys still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register write address |
| reg_wdata | input | 16 | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | 16 | Register read data (combinational) |
| busy | output | 1 | Command in progress |
| age_time | output | 8 | Stored age-time setting |
| learn_all | output | 1 | Stored learn-to-all enable |

## Verification
The hardest conditions to reach from the ports are a completely full table and a move that empties an entry's port vector. The bench reaches the full table by flushing everything and then loading DEPTH distinct keys. It then offers one more key and confirms with get-next that the key is absent while an existing key can still be overwritten. For the move corner, entries are loaded with one- and two-port vectors plus a static entry. A move and then a port removal are applied, and the whole database is read back with get-next iteration, so every vector and every survivor is seen at the register interface.

// File: rtl/mac_tbl_pkg.sv
// Shared types and constants for the MAC table engine.
// Assumes NPORTS is even and at most 11 so the vector fits the data word.
package mac_tbl_pkg;
    parameter int NPORTS = 8;
    parameter int DB_W   = 8;
    localparam int MAC_W = 48;

    typedef struct packed {
        logic [DB_W-1:0]   db;
        logic [MAC_W-1:0]  mac;
        logic [3:0]        state;
        logic              trunk;
        logic [NPORTS-1:0] pv;
    } entry_t;

    localparam logic [2:0] OP_FM_ALL    = 3'd1;
    localparam logic [2:0] OP_FM_NS     = 3'd2;
    localparam logic [2:0] OP_LOAD      = 3'd3;
    localparam logic [2:0] OP_NEXT      = 3'd4;
    localparam logic [2:0] OP_FM_ALL_DB = 3'd5;
    localparam logic [2:0] OP_FM_NS_DB  = 3'd6;

    localparam logic [3:0] ST_FREE   = 4'h0;
    localparam logic [3:0] ST_STATIC = 4'hE;
    localparam logic [3:0] ST_MOVE   = 4'hF;

    localparam logic [7:0] AGE_RST = 8'd20;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_CMD  = 3'd1;
    localparam logic [2:0] A_DATA = 3'd2;
    localparam logic [2:0] A_MAC0 = 3'd3;
    localparam logic [2:0] A_MAC1 = 3'd4;
    localparam logic [2:0] A_MAC2 = 3'd5;
endpackage

// File: rtl/mac_tbl_regs.sv
// Host register file: control, command, data and three MAC words.
// Host writes are ignored while busy; a result strobe from the engine
// replaces the MAC and data registers at the end of a get-next.
module mac_tbl_regs
    import mac_tbl_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic [2:0]              addr,
    input  logic [15:0]             wdata,
    input  logic [2:0]              raddr,
    output logic [15:0]             rdata,
    input  logic                    busy,
    input  logic                    res_valid,
    input  logic [MAC_W-1:0]        res_mac,
    input  logic [3:0]              res_state,
    input  logic                    res_trunk,
    input  logic [NPORTS-1:0]       res_pv,
    output logic                    start,
    output logic [2:0]              opcode,
    output logic [DB_W-1:0]         db,
    output logic [MAC_W-1:0]        key_mac,
    output logic [3:0]              cmd_state,
    output logic                    cmd_trunk,
    output logic [NPORTS-1:0]       cmd_pv,
    output logic [7:0]              age_time,
    output logic                    learn_all
);
    logic [3:0]        db_hi_q, db_lo_q;
    logic [7:0]        age_q;
    logic              learn_q;
    logic [2:0]        op_q;
    logic [3:0]        st_q;
    logic              tr_q;
    logic [NPORTS-1:0] pv_q;
    logic [MAC_W-1:0]  mac_q;
    logic              host_wr;

    assign host_wr = wr && !busy;
    assign start   = host_wr && (addr == A_CMD) && wdata[15];

    // Register update: reset, engine result, or accepted host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            db_hi_q <= '0;
            db_lo_q <= '0;
            age_q   <= AGE_RST;
            learn_q <= 1'b0;
            op_q    <= '0;
            st_q    <= '0;
            tr_q    <= 1'b0;
            pv_q    <= '0;
            mac_q   <= '0;
        end else if (res_valid) begin
            mac_q <= res_mac;
            st_q  <= res_state;
            tr_q  <= res_trunk;
            pv_q  <= res_pv;
        end else if (host_wr) begin
            case (addr)
                A_CTRL: begin
                    db_hi_q <= wdata[15:12];
                    learn_q <= wdata[3];
                    if (wdata[11:4] != 8'd0) age_q <= wdata[11:4];
                end
                A_CMD: begin
                    op_q    <= wdata[14:12];
                    db_lo_q <= wdata[3:0];
                end
                A_DATA: begin
                    st_q <= wdata[3:0];
                    tr_q <= wdata[15];
                    pv_q <= wdata[4 +: NPORTS];
                end
                A_MAC0:  mac_q[47:32] <= wdata;
                A_MAC1:  mac_q[31:16] <= wdata;
                A_MAC2:  mac_q[15:0]  <= wdata;
                default: ;
            endcase
        end
    end

    // Read mux over the register map.
    always_comb begin
        rdata = '0;
        case (raddr)
            A_CTRL: rdata = {db_hi_q, age_q, learn_q, 3'b000};
            A_CMD:  rdata = {busy, op_q, 8'h00, db_lo_q};
            A_DATA: begin
                rdata[15]          = tr_q;
                rdata[4 +: NPORTS] = pv_q;
                rdata[3:0]         = st_q;
            end
            A_MAC0:  rdata = mac_q[47:32];
            A_MAC1:  rdata = mac_q[31:16];
            A_MAC2:  rdata = mac_q[15:0];
            default: rdata = '0;
        endcase
    end

    assign opcode    = op_q;
    assign db        = {db_hi_q, db_lo_q};
    assign key_mac   = mac_q;
    assign cmd_state = st_q;
    assign cmd_trunk = tr_q;
    assign cmd_pv    = pv_q;
    assign age_time  = age_q;
    assign learn_all = learn_q;
endmodule

// File: rtl/mac_tbl_store.sv
// Entry array with one combinational read port and one write port.
// A slot whose state is zero is free; reset frees every slot.
module mac_tbl_store
    import mac_tbl_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] ridx,
    output entry_t           rentry,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  entry_t           wentry
);
    entry_t mem [DEPTH];

    // Slot storage: clear on reset, single write per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[widx] <= wentry;
        end
    end

    assign rentry = mem[ridx];
endmodule

// File: rtl/mac_tbl_ctrl.sv
// Command sequencer: visits every slot once (DEPTH cycles), then spends
// one cycle committing. Flush/move rewrite slots during the walk; load
// and get-next gather a result during the walk and act at the end.
// Assumes the command inputs are held stable while busy.
module mac_tbl_ctrl
    import mac_tbl_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int MW    = NPORTS / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        opcode,
    input  logic [DB_W-1:0]   db,
    input  logic [MAC_W-1:0]  key_mac,
    input  logic [3:0]        cmd_state,
    input  logic              cmd_trunk,
    input  logic [NPORTS-1:0] cmd_pv,
    output logic              busy,
    output logic [IDX_W-1:0]  ridx,
    input  entry_t            rentry,
    output logic              st_we,
    output logic [IDX_W-1:0]  st_widx,
    output entry_t            st_wentry,
    output logic              res_valid,
    output logic [MAC_W-1:0]  res_mac,
    output logic [3:0]        res_state,
    output logic              res_trunk,
    output logic [NPORTS-1:0] res_pv
);
    typedef enum logic [1:0] {S_IDLE, S_SCAN, S_DONE} fsm_e;

    fsm_e             state_q;
    logic [IDX_W-1:0] idx_q, hit_idx_q, free_idx_q;
    logic             hit_q, free_q, found_q;
    entry_t           best_q;

    logic              valid, db_hit, is_fm, all_db, ns_only, sel, fm_act, nx_cand;
    logic [NPORTS-1:0] src_bit, dst_bit;
    entry_t            moved, load_entry;

    // Per-slot decode of the entry under the walk pointer.
    always_comb begin
        valid   = rentry.state != ST_FREE;
        db_hit  = rentry.db == db;
        is_fm   = (opcode == OP_FM_ALL) || (opcode == OP_FM_NS) ||
                  (opcode == OP_FM_ALL_DB) || (opcode == OP_FM_NS_DB);
        all_db  = (opcode == OP_FM_ALL) || (opcode == OP_FM_NS);
        ns_only = (opcode == OP_FM_NS) || (opcode == OP_FM_NS_DB);
        sel     = valid && (all_db || db_hit) && (!ns_only || rentry.state != ST_STATIC);
        src_bit = NPORTS'(1) << cmd_pv[MW-1:0];
        dst_bit = (&cmd_pv[2*MW-1:MW]) ? '0 : NPORTS'(1) << cmd_pv[2*MW-1:MW];
        fm_act  = (cmd_state == ST_FREE) ||
                  ((cmd_state == ST_MOVE) && |(rentry.pv & src_bit));
        moved    = rentry;
        moved.pv = (rentry.pv & ~src_bit) | dst_bit;
        if (moved.pv == '0) moved = '0;
        nx_cand = valid && db_hit && ((&key_mac) || (rentry.mac > key_mac));
        load_entry = '{db: db, mac: key_mac, state: cmd_state, trunk: cmd_trunk, pv: cmd_pv};
    end

    // Sequencer state and result gathering.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            idx_q      <= '0;
            hit_idx_q  <= '0;
            free_idx_q <= '0;
            hit_q      <= 1'b0;
            free_q     <= 1'b0;
            found_q    <= 1'b0;
            best_q     <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (start) begin
                    state_q <= S_SCAN;
                    idx_q   <= '0;
                    hit_q   <= 1'b0;
                    free_q  <= 1'b0;
                    found_q <= 1'b0;
                end
                S_SCAN: begin
                    if (opcode == OP_LOAD) begin
                        if (valid && db_hit && rentry.mac == key_mac) begin
                            hit_q     <= 1'b1;
                            hit_idx_q <= idx_q;
                        end
                        if (!valid && !free_q) begin
                            free_q     <= 1'b1;
                            free_idx_q <= idx_q;
                        end
                    end
                    if (opcode == OP_NEXT && nx_cand &&
                        (!found_q || rentry.mac < best_q.mac)) begin
                        found_q <= 1'b1;
                        best_q  <= rentry;
                    end
                    if (idx_q == IDX_W'(DEPTH - 1)) state_q <= S_DONE;
                    else idx_q <= idx_q + 1'b1;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Table write selection for the walk and the commit cycle.
    always_comb begin
        st_we     = 1'b0;
        st_widx   = idx_q;
        st_wentry = '0;
        if (state_q == S_SCAN && is_fm && sel && fm_act) begin
            st_we     = 1'b1;
            st_wentry = (cmd_state == ST_FREE) ? '0 : moved;
        end else if (state_q == S_DONE && opcode == OP_LOAD) begin
            if (cmd_state != ST_FREE) begin
                st_we     = hit_q || free_q;
                st_widx   = hit_q ? hit_idx_q : free_idx_q;
                st_wentry = load_entry;
            end else begin
                st_we   = hit_q;
                st_widx = hit_idx_q;
            end
        end
    end

    assign busy      = state_q != S_IDLE;
    assign ridx      = idx_q;
    assign res_valid = (state_q == S_DONE) && (opcode == OP_NEXT);
    assign res_mac   = found_q ? best_q.mac : '1;
    assign res_state = found_q ? best_q.state : ST_FREE;
    assign res_trunk = found_q && best_q.trunk;
    assign res_pv    = found_q ? best_q.pv : '0;
endmodule

// File: rtl/mac_tbl_engine.sv
// Top level: register file, command sequencer and entry array.
// Assumes the host polls busy before issuing the next command.
module mac_tbl_engine
    import mac_tbl_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    input  logic [2:0]  reg_raddr,
    output logic [15:0] reg_rdata,
    output logic        busy,
    output logic [7:0]  age_time,
    output logic        learn_all
);
    localparam int IDX_W = $clog2(DEPTH);

    logic              start, res_valid, st_we, cmd_trunk, res_trunk;
    logic [2:0]        opcode;
    logic [DB_W-1:0]   db;
    logic [MAC_W-1:0]  key_mac, res_mac;
    logic [3:0]        cmd_state, res_state;
    logic [NPORTS-1:0] cmd_pv, res_pv;
    logic [IDX_W-1:0]  ridx, st_widx;
    entry_t            rentry, st_wentry;

    mac_tbl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .raddr(reg_raddr), .rdata(reg_rdata), .busy(busy),
        .res_valid(res_valid), .res_mac(res_mac), .res_state(res_state),
        .res_trunk(res_trunk), .res_pv(res_pv),
        .start(start), .opcode(opcode), .db(db), .key_mac(key_mac),
        .cmd_state(cmd_state), .cmd_trunk(cmd_trunk), .cmd_pv(cmd_pv),
        .age_time(age_time), .learn_all(learn_all)
    );

    mac_tbl_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .db(db),
        .key_mac(key_mac), .cmd_state(cmd_state), .cmd_trunk(cmd_trunk),
        .cmd_pv(cmd_pv), .busy(busy), .ridx(ridx), .rentry(rentry),
        .st_we(st_we), .st_widx(st_widx), .st_wentry(st_wentry),
        .res_valid(res_valid), .res_mac(res_mac), .res_state(res_state),
        .res_trunk(res_trunk), .res_pv(res_pv)
    );

    mac_tbl_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .ridx(ridx), .rentry(rentry),
        .we(st_we), .widx(st_widx), .wentry(st_wentry)
    );
endmodule

// File: rtl/mac_tbl_engine_sva.sv
// Checker for the MAC table engine, attached to the top by bind.
// Watches the host port, busy, the exported control fields and table writes.
module mac_tbl_engine_sva #(
    parameter int DEPTH = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [2:0]  reg_addr,
    input logic [15:0] reg_wdata,
    input logic        busy,
    input logic [7:0]  age_time,
    input logic        learn_all,
    input logic        st_we
);
    int unsigned busy_cnt;

    // Count consecutive busy cycles to bound the command length.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_cnt <= 0;
        else if (busy) busy_cnt <= busy_cnt + 1;
        else busy_cnt <= 0;
    end

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd1 && reg_wdata[15] && !busy) |=> busy);

    assert_busy_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> busy_cnt <= DEPTH);

    assert_idle_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !st_we);

    assert_ctrl_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(age_time) && $stable(learn_all)));

    assert_age_nonzero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        age_time != 8'd0);

    assert_age_zero_kept_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !busy && reg_addr == 3'd0 && reg_wdata[11:4] == 8'd0) |=> $stable(age_time));
endmodule

bind mac_tbl_engine mac_tbl_engine_sva #(.DEPTH(DEPTH)) u_sva (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .age_time(age_time),
    .learn_all(learn_all), .st_we(st_we)
);

// File: tb/mac_tbl_engine_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module mac_tbl_engine_tb;
    localparam int DEPTH = 16;
    localparam logic [47:0] ONES = 48'hFFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [2:0]  reg_raddr = '0;
    logic [15:0] reg_rdata;
    logic        busy;
    logic [7:0]  age_time;
    logic        learn_all;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;
    logic [15:0] ctrl_sh = 16'h0140;

    mac_tbl_engine #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .busy(busy), .age_time(age_time), .learn_all(learn_all)
    );

    always #4 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog R2 actual busy=%0d expected 0", busy);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        reg_raddr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic run(input logic [2:0] op, input logic [7:0] db);
        ctrl_sh[15:12] = db[7:4];
        wr(3'd0, ctrl_sh);
        wr(3'd1, {1'b1, op, 8'h00, db[3:0]});
        while (busy) @(negedge clk);
    endtask

    task automatic set_mac(input logic [47:0] m);
        wr(3'd3, m[47:32]); wr(3'd4, m[31:16]); wr(3'd5, m[15:0]);
    endtask

    task automatic set_data(input logic [3:0] st, input logic tr, input logic [7:0] pv);
        wr(3'd2, {tr, 3'b000, pv, st});
    endtask

    task automatic load(input logic [7:0] db, input logic [47:0] m,
                        input logic [3:0] st, input logic tr, input logic [7:0] pv);
        set_mac(m);
        set_data(st, tr, pv);
        run(3'd3, db);
    endtask

    task automatic nxt(input logic [7:0] db, output logic [47:0] m, output logic [15:0] d);
        logic [15:0] w0, w1, w2;
        run(3'd4, db);
        rd(3'd3, w0); rd(3'd4, w1); rd(3'd5, w2); rd(3'd2, d);
        m = {w0, w1, w2};
    endtask

    task automatic t_reset;
        logic [15:0] v; logic [47:0] m;
        rd(3'd0, v); chk("R1 ctrl reset", v, 16'h0140);
        rd(3'd1, v); chk("R1 cmd reset", v, 16'h0000);
        rd(3'd2, v); chk("R1 data reset", v, 16'h0000);
        chk("R1 busy reset", busy, 1'b0);
        set_mac(ONES);
        nxt(8'h00, m, v);
        chk("R1 R7 empty mac", m, ONES);
        chk("R1 R7 empty data", v, 16'h0000);
    endtask

    task automatic t_layout;
        logic [15:0] v; logic [47:0] m;
        load(8'h00, 48'h1122_3344_5566, 4'h7, 1'b0, 8'h05);
        set_mac(ONES);
        run(3'd4, 8'h00);
        rd(3'd3, v); chk("R4 mac word0", v, 16'h1122);
        rd(3'd4, v); chk("R4 mac word1", v, 16'h3344);
        rd(3'd5, v); chk("R4 mac word2", v, 16'h5566);
        rd(3'd2, v); chk("R4 data word", v, 16'h0057);
        nxt(8'h00, m, v);
        chk("R7 end after last", m, ONES);
    endtask

    task automatic t_order;
        logic [15:0] v; logic [47:0] m;
        load(8'h05, 48'h100, 4'h7, 1'b0, 8'h01);
        load(8'h05, 48'h300, 4'h7, 1'b0, 8'h04);
        load(8'h05, 48'h200, 4'h7, 1'b0, 8'h02);
        set_mac(ONES);
        nxt(8'h05, m, v); chk("R8 lowest first", m, 48'h100);
        nxt(8'h05, m, v); chk("R7 second", m, 48'h200); chk("R7 second data", v, 16'h0027);
        nxt(8'h05, m, v); chk("R7 third", m, 48'h300);
        nxt(8'h05, m, v); chk("R7 end mac", m, ONES); chk("R7 end data", v, 16'h0000);
        set_mac(48'h150);
        nxt(8'h05, m, v); chk("R7 mid start", m, 48'h200);
    endtask

    task automatic t_db;
        logic [15:0] v; logic [47:0] m;
        load(8'h35, 48'h180, 4'h7, 1'b0, 8'h08);
        set_mac(48'h150);
        nxt(8'h05, m, v); chk("R3 other db hidden", m, 48'h200);
        set_mac(ONES);
        nxt(8'h35, m, v); chk("R3 upper nibble db", m, 48'h180);
        nxt(8'h35, m, v); chk("R3 db end", m, ONES);
    endtask

    task automatic t_overwrite_purge;
        logic [15:0] v; logic [47:0] m;
        load(8'h05, 48'h100, 4'hE, 1'b1, 8'h03);
        set_mac(ONES);
        nxt(8'h05, m, v); chk("R5 overwrite mac", m, 48'h100); chk("R5 overwrite data", v, 16'h803E);
        load(8'h05, 48'h300, 4'h0, 1'b0, 8'h00);
        set_mac(48'h200);
        nxt(8'h05, m, v); chk("R6 purged gone", m, ONES);
    endtask

    task automatic t_busy;
        logic [15:0] v; int n;
        set_mac(ONES);
        ctrl_sh[15:12] = 4'h0;
        wr(3'd0, ctrl_sh);
        wr(3'd1, {1'b1, 3'd4, 8'h00, 4'h5});
        chk("R2 busy after start", busy, 1'b1);
        rd(3'd1, v); chk("R2 busy readback", v[15], 1'b1);
        @(negedge clk); reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 16'hF770;
        @(negedge clk); reg_wr = 1'b0;
        n = 2;
        while (busy) begin n++; @(negedge clk); end
        chk("R2 busy length", n, DEPTH + 1);
        rd(3'd0, v); chk("R2 write while busy ignored", v, ctrl_sh);
        rd(3'd3, v); chk("R2 result after busy", v, 16'h0000);
    endtask

    task automatic t_flush;
        logic [15:0] v; logic [47:0] m;
        load(8'h05, 48'h200, 4'h7, 1'b0, 8'h02);
        set_data(4'h0, 1'b0, 8'h00);
        run(3'd6, 8'h05);
        set_mac(ONES);
        nxt(8'h05, m, v); chk("R9 static kept", m, 48'h100);
        nxt(8'h05, m, v); chk("R9 dynamic flushed", m, ONES);
        set_mac(ONES);
        nxt(8'h35, m, v); chk("R9 R3 other db kept", m, 48'h180);
        set_data(4'h0, 1'b0, 8'h00);
        run(3'd1, 8'h00);
        set_mac(ONES);
        nxt(8'h05, m, v); chk("R9 flush all static gone", m, ONES);
        set_mac(ONES);
        nxt(8'h35, m, v); chk("R9 flush all dbs", m, ONES);
    endtask

    task automatic t_move;
        logic [15:0] v; logic [47:0] m;
        load(8'h02, 48'h10, 4'h7, 1'b0, 8'h01);
        load(8'h02, 48'h20, 4'h7, 1'b0, 8'h03);
        load(8'h02, 48'h30, 4'h7, 1'b0, 8'h02);
        load(8'h02, 48'h40, 4'hE, 1'b0, 8'h01);
        set_data(4'hF, 1'b0, 8'h40);
        run(3'd2, 8'h00);
        set_mac(ONES);
        nxt(8'h02, m, v); chk("R10 moved single", v, 16'h0107);
        nxt(8'h02, m, v); chk("R10 moved pair", v, 16'h0127);
        nxt(8'h02, m, v); chk("R10 untouched", v, 16'h0027);
        nxt(8'h02, m, v); chk("R10 static spared", v, 16'h001E);
        set_data(4'hF, 1'b0, 8'hF1);
        run(3'd1, 8'h00);
        set_mac(ONES);
        nxt(8'h02, m, v); chk("R11 no src kept", v, 16'h0107);
        nxt(8'h02, m, v); chk("R11 src bit cleared", v, 16'h0107);
        nxt(8'h02, m, v); chk("R11 emptied removed", m, 48'h40);
        nxt(8'h02, m, v); chk("R11 end", m, ONES);
    endtask

    task automatic t_ctrl;
        logic [15:0] v;
        ctrl_sh = 16'h0338;
        wr(3'd0, ctrl_sh);
        rd(3'd0, v); chk("R12 ctrl readback", v, 16'h0338);
        chk("R12 age port", age_time, 8'h33);
        chk("R12 learn port", learn_all, 1'b1);
        wr(3'd0, 16'h0000);
        rd(3'd0, v); chk("R12 zero age kept", v, 16'h0330);
        chk("R12 learn cleared", learn_all, 1'b0);
        ctrl_sh = 16'h0330;
    endtask

    task automatic t_full;
        logic [15:0] v; logic [47:0] m;
        set_data(4'h0, 1'b0, 8'h00);
        run(3'd1, 8'h00);
        for (int i = 0; i < DEPTH; i++) load(8'h01, 48'h100 + 48'(i), 4'h7, 1'b0, 8'h01);
        load(8'h01, 48'h999, 4'h7, 1'b0, 8'h01);
        set_mac(48'h998);
        nxt(8'h01, m, v); chk("R13 full load dropped", m, ONES);
        load(8'h01, 48'h105, 4'h5, 1'b0, 8'h02);
        set_mac(48'h104);
        nxt(8'h01, m, v); chk("R13 overwrite when full", m, 48'h105);
        chk("R13 overwrite data", v, 16'h0025);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_layout;
        t_order;
        t_db;
        t_overwrite_purge;
        t_busy;
        t_flush;
        t_move;
        t_ctrl;
        t_full;
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule